// File: doc/BRIEF.md
# Device-Side Block Pull DMA Front End

This block moves a block of data from a host-side DMA channel into a region of device memory. Software sets up three things through a small register port: a device destination address, a byte count and a region select. It then writes a start bit. While the transfer runs, the block holds a request towards the host channel. Each time the host acknowledges the request, the block takes one 32-byte unit. The unit is written to device memory at the destination plus the bytes already moved, and the remaining count drops by one unit.

When the last unit has been taken, the request drops, the start bit clears itself and a one-cycle completion event fires. Writing zero to the control register aborts a transfer that is running. An abort leaves the remaining count readable and raises no completion event. The destination register is never advanced; the running write address is kept inside the block. The region select is latched at start and travels with every memory write, but it always reads back as zero.

Top module: `devpull_dma`

## Requirements
- R1: After a synchronous reset, the control, count and destination registers read 0, `host_req`, `mem_we` and `xfer_done` are low.
- R2: Register offsets on `cfg_addr` are: destination 0x00, byte count 0x04, control 0x08 (bit 0 = run), region 0x84. The destination reads back as written. The count stores the written value with its low 5 bits cleared. The region register and every unlisted offset read 0.
- R3: Writing 1 to control bit 0 while idle with a nonzero count raises `host_req` in the next cycle, and control then reads 1.
- R4: A unit is accepted on a clock edge where `host_req` and `host_ack` are both high. On that edge the count drops by 32. In the next cycle `mem_we` is high for one cycle, with `mem_addr` = destination + 32 × (units already accepted), `mem_data` = the `host_data` sampled at acceptance, and `mem_region` = the region value held when the transfer started.
- R5: `host_req` is low in the cycle after the final unit is accepted. Afterwards control reads 0, count reads 0 and the destination still reads its programmed value.
- R6: `xfer_done` is high for exactly one cycle, the cycle after the final unit is accepted, which is the same cycle as the last memory write.
- R7: Writing 0 to control while a transfer runs makes `host_req` low in the next cycle and raises no `xfer_done`. The count keeps the number of bytes not yet moved.
- R8: While a transfer runs, writes to the destination and count registers are ignored, and writing 1 to control again does not restart the address sequence.
- R9: Starting with a count of 0 raises no request. `xfer_done` pulses in the next cycle and control reads 0.
- R10: `host_ack` while `host_req` is low causes no memory write and no change in the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register byte offset for reads and writes |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr` (combinational) |
| host_req | output | 1 | Request for the next unit from the host channel |
| host_ack | input | 1 | Host hands over a unit this cycle |
| host_data | input | 256 | One 32-byte unit of data |
| mem_we | output | 1 | Device memory write strobe |
| mem_addr | output | 32 | Device memory byte address of the unit |
| mem_region | output | 2 | Region select latched at start |
| mem_data | output | 256 | Unit data written to device memory |
| xfer_done | output | 1 | One-cycle completion event |

## Verification
The transfer path runs over a table of transfers with different lengths, from a single unit to four units. The host acknowledges every cycle in some entries and after idle gaps of one or two cycles in others. This separates address stepping from request handshake timing. Each entry uses a distinct destination and region, and the data of every unit is unique, so a stale address, a region taken at the wrong time or a data word sampled in the wrong cycle show up as mismatches. Directed cases then cover an abort in the middle of a transfer, configuration writes made while a transfer runs, a start with a zero count, and acknowledges given while no request is pending. These separate completion from abort, and a real acceptance from a stray acknowledge.

// File: rtl/devpull_pkg.sv
`timescale 1ns/1ps
package devpull_pkg;

    localparam int REG_W = 32;

    localparam logic [7:0] OFS_DEST   = 8'h00;
    localparam logic [7:0] OFS_COUNT  = 8'h04;
    localparam logic [7:0] OFS_CTRL   = 8'h08;
    localparam logic [7:0] OFS_REGION = 8'h84;

    // Decoded register-port actions handed to the sequencer
    typedef struct packed {
        logic start;
        logic stop;
        logic cnt_ld;
    } cmd_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } xfer_state_t;

    function automatic logic hit(input logic [7:0] addr, input logic [7:0] ofs);
        return addr == ofs;
    endfunction

endpackage

// File: rtl/devpull_regs.sv
`timescale 1ns/1ps
module devpull_regs
    import devpull_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int CNT_W    = 32,
    parameter int REGION_W = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_wr,
    input  logic [7:0]          cfg_addr,
    input  logic [REG_W-1:0]    cfg_wdata,
    input  logic                busy,
    input  logic [CNT_W-1:0]    remaining,
    output cmd_t                cmd,
    output logic [ADDR_W-1:0]   dest_q,
    output logic [REGION_W-1:0] region_q,
    output logic [REG_W-1:0]    cfg_rdata
);

    // Destination and region storage; destination frozen while running
    always_ff @(posedge clk) begin
        if (rst) begin
            dest_q   <= '0;
            region_q <= '0;
        end else if (cfg_wr) begin
            if (hit(cfg_addr, OFS_DEST) && !busy)
                dest_q <= cfg_wdata[ADDR_W-1:0];
            if (hit(cfg_addr, OFS_REGION))
                region_q <= cfg_wdata[REGION_W-1:0];
        end
    end

    always_comb begin
        cmd.start  = cfg_wr && hit(cfg_addr, OFS_CTRL) &&  cfg_wdata[0];
        cmd.stop   = cfg_wr && hit(cfg_addr, OFS_CTRL) && !cfg_wdata[0];
        cmd.cnt_ld = cfg_wr && hit(cfg_addr, OFS_COUNT);
    end

    // Read mux; region is write-only from the port's view
    always_comb begin
        unique case (cfg_addr)
            OFS_DEST:  cfg_rdata = REG_W'(dest_q);
            OFS_COUNT: cfg_rdata = REG_W'(remaining);
            OFS_CTRL:  cfg_rdata = REG_W'(busy);
            default:   cfg_rdata = '0;
        endcase
    end

    // R8: destination cannot move while a transfer runs
    assert_dest_hold_R8: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(dest_q));

endmodule

// File: rtl/devpull_xfer.sv
`timescale 1ns/1ps
module devpull_xfer
    import devpull_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int CNT_W      = 32,
    parameter int REGION_W   = 2,
    parameter int UNIT_BYTES = 32
) (
    input  logic                     clk,
    input  logic                     rst,
    input  cmd_t                     cmd,
    input  logic [CNT_W-1:$clog2(UNIT_BYTES)] cnt_units,
    input  logic [REGION_W-1:0]      region_in,
    input  logic                     host_ack,
    output logic                     host_req,
    output logic                     busy,
    output logic                     accept,
    output logic                     done,
    output logic [CNT_W-1:0]         remaining,
    output logic [ADDR_W-1:0]        offset,
    output logic [REGION_W-1:0]      region_snap
);

    localparam int              SHIFT    = $clog2(UNIT_BYTES);
    localparam logic [CNT_W-1:0]  UNIT_C = CNT_W'(UNIT_BYTES);
    localparam logic [ADDR_W-1:0] UNIT_A = ADDR_W'(UNIT_BYTES);

    xfer_state_t state;
    logic        last_unit;

    assign busy      = (state == ST_RUN);
    assign done      = (state == ST_FIN);
    assign host_req  = busy && (remaining != '0);
    assign accept    = host_req && host_ack;
    assign last_unit = (remaining == UNIT_C);

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            remaining   <= '0;
            offset      <= '0;
            region_snap <= '0;
        end else begin
            unique case (state)
                ST_RUN: begin
                    if (accept) begin
                        remaining <= remaining - UNIT_C;
                        offset    <= offset + UNIT_A;
                    end
                    if (cmd.stop)
                        state <= ST_IDLE;
                    else if (accept && last_unit)
                        state <= ST_FIN;
                end
                default: begin
                    if (cmd.cnt_ld)
                        remaining <= {cnt_units, SHIFT'(0)};
                    if (cmd.start) begin
                        offset      <= '0;
                        region_snap <= region_in;
                        state       <= (remaining == '0) ? ST_FIN : ST_RUN;
                    end else begin
                        state <= ST_IDLE;
                    end
                end
            endcase
        end
    end

    // R4: every accepted unit removes one unit from the count
    assert_count_step_R4: assert property (@(posedge clk) disable iff (rst)
        accept |=> remaining == $past(remaining) - UNIT_C);

    // R5: request is gone after the final unit is taken
    assert_req_fall_R5: assert property (@(posedge clk) disable iff (rst)
        (accept && last_unit) |=> !host_req);

    // R6: completion lasts one cycle unless a new start follows it
    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done || $past(cmd.start)));

    // R7: abort ends the request without a completion event
    assert_abort_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        (busy && cmd.stop) |=> (!done && !host_req));

endmodule

// File: rtl/devpull_wstage.sv
`timescale 1ns/1ps
module devpull_wstage #(
    parameter int ADDR_W   = 32,
    parameter int REGION_W = 2,
    parameter int DATA_W   = 256
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                accept,
    input  logic [ADDR_W-1:0]   base,
    input  logic [ADDR_W-1:0]   offset,
    input  logic [REGION_W-1:0] region,
    input  logic [DATA_W-1:0]   data,
    output logic                mem_we,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [REGION_W-1:0] mem_region,
    output logic [DATA_W-1:0]   mem_data
);

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_we     <= 1'b0;
            mem_addr   <= '0;
            mem_region <= '0;
            mem_data   <= '0;
        end else begin
            mem_we <= accept;
            if (accept) begin
                mem_addr   <= base + offset;
                mem_region <= region;
                mem_data   <= data;
            end
        end
    end

    // R4: an accepted unit is written in the following cycle
    assert_write_follows_R4: assert property (@(posedge clk) disable iff (rst)
        accept |=> mem_we);

    // R10: no write without an acceptance
    assert_no_stray_write_R10: assert property (@(posedge clk) disable iff (rst)
        !accept |=> !mem_we);

endmodule

// File: rtl/devpull_dma.sv
`timescale 1ns/1ps
module devpull_dma
    import devpull_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int CNT_W      = 32,
    parameter int REGION_W   = 2,
    parameter int UNIT_BYTES = 32
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      cfg_wr,
    input  logic [7:0]                cfg_addr,
    input  logic [31:0]               cfg_wdata,
    output logic [31:0]               cfg_rdata,
    output logic                      host_req,
    input  logic                      host_ack,
    input  logic [UNIT_BYTES*8-1:0]   host_data,
    output logic                      mem_we,
    output logic [ADDR_W-1:0]         mem_addr,
    output logic [REGION_W-1:0]       mem_region,
    output logic [UNIT_BYTES*8-1:0]   mem_data,
    output logic                      xfer_done
);

    localparam int DATA_W = UNIT_BYTES * 8;
    localparam int SHIFT  = $clog2(UNIT_BYTES);

    cmd_t                cmd;
    logic                busy;
    logic                accept;
    logic [CNT_W-1:0]    remaining;
    logic [ADDR_W-1:0]   dest_q;
    logic [ADDR_W-1:0]   offset;
    logic [REGION_W-1:0] region_q;
    logic [REGION_W-1:0] region_snap;

    devpull_regs #(
        .ADDR_W   (ADDR_W),
        .CNT_W    (CNT_W),
        .REGION_W (REGION_W)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .cfg_wr    (cfg_wr),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .busy      (busy),
        .remaining (remaining),
        .cmd       (cmd),
        .dest_q    (dest_q),
        .region_q  (region_q),
        .cfg_rdata (cfg_rdata)
    );

    devpull_xfer #(
        .ADDR_W     (ADDR_W),
        .CNT_W      (CNT_W),
        .REGION_W   (REGION_W),
        .UNIT_BYTES (UNIT_BYTES)
    ) u_xfer (
        .clk         (clk),
        .rst         (rst),
        .cmd         (cmd),
        .cnt_units   (cfg_wdata[CNT_W-1:SHIFT]),
        .region_in   (region_q),
        .host_ack    (host_ack),
        .host_req    (host_req),
        .busy        (busy),
        .accept      (accept),
        .done        (xfer_done),
        .remaining   (remaining),
        .offset      (offset),
        .region_snap (region_snap)
    );

    devpull_wstage #(
        .ADDR_W   (ADDR_W),
        .REGION_W (REGION_W),
        .DATA_W   (DATA_W)
    ) u_wstage (
        .clk        (clk),
        .rst        (rst),
        .accept     (accept),
        .base       (dest_q),
        .offset     (offset),
        .region     (region_snap),
        .data       (host_data),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_region (mem_region),
        .mem_data   (mem_data)
    );

    // R6: completion always coincides with the last memory write
    assert_done_with_write_R6: assert property (@(posedge clk) disable iff (rst)
        (xfer_done && $past(busy)) |-> mem_we);

endmodule

// File: tb/sim_devpull_dma.sv
`timescale 1ns/1ps
module sim_devpull_dma;

    localparam int NV = 4;
    localparam logic [31:0] V_DEST [NV] = '{32'h0000_1000, 32'h0002_0040, 32'h00A0_0000, 32'hFFFF_FF00};
    localparam logic [31:0] V_CNT  [NV] = '{32'd32, 32'd128, 32'd96, 32'd64};
    localparam logic [1:0]  V_REG  [NV] = '{2'd1, 2'd2, 2'd3, 2'd0};
    localparam int          V_GAP  [NV] = '{0, 0, 2, 1};

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cfg_wr = 1'b0;
    logic [7:0]   cfg_addr = 8'h00;
    logic [31:0]  cfg_wdata = '0;
    logic [31:0]  cfg_rdata;
    logic         host_req;
    logic         host_ack = 1'b0;
    logic [255:0] host_data = '0;
    logic         mem_we;
    logic [31:0]  mem_addr;
    logic [1:0]   mem_region;
    logic [255:0] mem_data;
    logic         xfer_done;

    int  checks = 0;
    int  errors = 0;
    bit  finished = 1'b0;

    always #10 clk = ~clk;

    devpull_dma u0 (
        .clk        (clk),
        .rst        (rst),
        .cfg_wr     (cfg_wr),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .host_req   (host_req),
        .host_ack   (host_ack),
        .host_data  (host_data),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_region (mem_region),
        .mem_data   (mem_data),
        .xfer_done  (xfer_done)
    );

    task automatic check(input string req, input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        cfg_addr = a;
        #1;
        d = cfg_rdata;
    endtask

    function automatic logic [255:0] unit_pat(input int v, input int k);
        return {8{32'hC0DE_0000 ^ (32'(v) << 8) ^ 32'(k)}};
    endfunction

    // One unit handed over at the next edge; checks in the cycle after
    task automatic give_unit(input logic [255:0] d);
        host_ack = 1'b1; host_data = d;
        @(negedge clk);
        host_ack = 1'b0;
    endtask

    initial begin : watchdog
        #(20 * 100000);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL timeout (all requirements) actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1 req", 256'(host_req), 256'd0);
        check("R1 mem_we", 256'(mem_we), 256'd0);
        check("R1 done", 256'(xfer_done), 256'd0);
        rd(8'h00, r); check("R1 dest", 256'(r), 256'd0);
        rd(8'h04, r); check("R1 count", 256'(r), 256'd0);
        rd(8'h08, r); check("R1 ctrl", 256'(r), 256'd0);

        // R2 register map
        wr(8'h00, 32'h1234_5678);
        rd(8'h00, r); check("R2 dest readback", 256'(r), 256'h1234_5678);
        wr(8'h04, 32'h0000_0047);
        rd(8'h04, r); check("R2 count low bits cleared", 256'(r), 256'h40);
        wr(8'h84, 32'h3);
        rd(8'h84, r); check("R2 region reads zero", 256'(r), 256'd0);
        rd(8'h0C, r); check("R2 unlisted offset", 256'(r), 256'd0);

        // Table of transfers (R3 R4 R5 R6)
        for (int v = 0; v < NV; v++) begin
            int units;
            units = int'(V_CNT[v] >> 5);
            wr(8'h00, V_DEST[v]);
            wr(8'h04, V_CNT[v]);
            wr(8'h84, 32'(V_REG[v]));
            wr(8'h08, 32'h1);
            check("R3 req after start", 256'(host_req), 256'd1);
            rd(8'h08, r); check("R3 ctrl busy", 256'(r), 256'd1);
            for (int k = 0; k < units; k++) begin
                for (int g = 0; g < V_GAP[v]; g++) begin
                    @(negedge clk);
                    check("R10 no write during gap", 256'(mem_we), 256'd0);
                end
                give_unit(unit_pat(v, k));
                check("R4 mem_we", 256'(mem_we), 256'd1);
                check("R4 mem_addr", 256'(mem_addr), 256'(V_DEST[v] + 32'(32 * k)));
                check("R4 mem_region", 256'(mem_region), 256'(V_REG[v]));
                check("R4 mem_data", mem_data, unit_pat(v, k));
                rd(8'h04, r); check("R4 count step", 256'(r), 256'(V_CNT[v] - 32'(32 * (k + 1))));
                check("R6 done timing", 256'(xfer_done), 256'(k == units - 1));
                check("R5 req level", 256'(host_req), 256'(k != units - 1));
            end
            @(negedge clk);
            check("R6 done single cycle", 256'(xfer_done), 256'd0);
            check("R4 single write", 256'(mem_we), 256'd0);
            rd(8'h08, r); check("R5 ctrl cleared", 256'(r), 256'd0);
            rd(8'h04, r); check("R5 count zero", 256'(r), 256'd0);
            rd(8'h00, r); check("R5 dest kept", 256'(r), 256'(V_DEST[v]));
        end

        // R8 writes while running, then R7 abort
        wr(8'h00, 32'h0000_3000);
        wr(8'h04, 32'd96);
        wr(8'h84, 32'h2);
        wr(8'h08, 32'h1);
        wr(8'h00, 32'hDEAD_0000);
        wr(8'h04, 32'h400);
        rd(8'h00, r); check("R8 dest write ignored", 256'(r), 256'h3000);
        rd(8'h04, r); check("R8 count write ignored", 256'(r), 256'd96);
        give_unit(unit_pat(9, 0));
        check("R8 first address", 256'(mem_addr), 256'h3000);
        wr(8'h08, 32'h1);
        give_unit(unit_pat(9, 1));
        check("R8 restart ignored", 256'(mem_addr), 256'h3020);
        wr(8'h08, 32'h0);
        check("R7 req dropped", 256'(host_req), 256'd0);
        check("R7 no done", 256'(xfer_done), 256'd0);
        rd(8'h04, r); check("R7 count kept", 256'(r), 256'd32);
        rd(8'h08, r); check("R7 ctrl cleared", 256'(r), 256'd0);
        @(negedge clk);
        check("R7 still no done", 256'(xfer_done), 256'd0);

        // R10 acknowledge with no request pending
        give_unit(unit_pat(9, 2));
        check("R10 no write", 256'(mem_we), 256'd0);
        rd(8'h04, r); check("R10 count unchanged", 256'(r), 256'd32);

        // R9 start with zero count
        wr(8'h04, 32'd0);
        wr(8'h08, 32'h1);
        check("R9 done pulse", 256'(xfer_done), 256'd1);
        check("R9 no request", 256'(host_req), 256'd0);
        rd(8'h08, r); check("R9 ctrl zero", 256'(r), 256'd0);
        @(negedge clk);
        check("R9 done ends", 256'(xfer_done), 256'd0);
        check("R9 still no request", 256'(host_req), 256'd0);

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule